// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream has three wires: a bit clock, a channel-select (word) clock and a data line. All three are brought into the system clock domain through two-flop synchronizers. Each rising edge of the bit clock then yields one data bit, tagged with the level of the word clock at that moment. A 3-bit format code picks one of three framings. Every completed stereo frame is presented as a left/right pair of 24-bit words with a one-cycle valid strobe.

A slot is the run of bit-clock periods between two word-clock transitions. A finite-state machine tracks which slot is being collected:

- `ST_IDLE`: waits for a slot start after reset or after a format change.
- `ST_LEFT`: collects the left slot.
- `ST_RIGHT`: collects a right slot whose left partner was captured in full.
- `ST_SKIP`: collects a right slot whose left partner was not seen.

Transitions happen only at a slot start, that is, when the sampled word-clock level differs from the one at the previous bit:

| Transition | Condition and effect |
| --- | --- |
| IDLE→LEFT | The new slot is a left slot. |
| IDLE→SKIP | The new slot is a right slot. |
| LEFT→RIGHT | Stores the finished left word. |
| RIGHT→LEFT | Publishes the pair and pulses valid. |
| SKIP→LEFT | Publishes nothing. |
| any→IDLE | Taken whenever the format code differs from its value one cycle earlier. |

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and right after it, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: Format code 000 (left-justified): word clock high marks the left slot, and the bit taken at the first rising bit-clock edge of a slot is the MSB (bit 23). A word shorter than 24 bits lands in the upper bits and the rest are zero, even when the previous slot held data there.
- R3: Format code 001 (I2S): word clock low marks the left slot. The first bit of a slot is discarded and the MSB is the second bit.
- R4: Format code 010 (right-justified 16-bit): word clock high marks the left slot. The last 16 bits before the slot ends form the sample, placed in bits 23:8, and bits 7:0 are zero. The earlier bits of the 32-bit slot are ignored.
- R5: Format codes 011 to 111 behave exactly like code 000.
- R6: `valid_o` is a single-cycle pulse, raised when a right slot ends (at the first bit of the following left slot). `left_o` and `right_o` change only in the cycle `valid_o` is high.
- R7: A right slot with no fully captured left slot before it produces no `valid_o`. This covers the first I2S frame after reset, whose left slot begins with no word-clock transition.
- R8: A change of the format code abandons the frame in progress. No `valid_o` follows until a complete left slot and right slot have been received under the new code.
- R9: In codes 000 and 001, data bits beyond the 24th of a slot have no effect on the sample.
- R10: `valid_o` rises after the third system clock rising edge that sees the bit-clock input high, counting the first such edge as the first.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Channel-select word clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Framing select: 000 left-justified, 001 I2S, 010 right-justified 16-bit |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The hardest case to reach is a format change that lands in the middle of a right slot. At that point a left word is already held but must never be published. The stimulus sends a left-justified frame and a full left slot, switches the code partway through the following right slot, and then streams right-justified frames. A scoreboard accepts only the frames that follow. The I2S start-up case is reached by releasing reset with the word clock low, so the first left slot has no transition to announce it. A behavioural model fed from the same pin history is compared on every clock and catches any extra or early strobe.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_SKIP  = 2'd3
    } state_e;

    localparam logic [2:0] CODE_I2S = 3'b001;
    localparam logic [2:0] CODE_RJ  = 3'b010;

    // Unlisted codes fall back to left-justified framing
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        case (code)
            CODE_I2S: return FMT_I2S;
            CODE_RJ:  return FMT_RJ;
            default:  return FMT_LJ;
        endcase
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sap_front.sv
module sap_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic lrck_i,
    input  logic sdata_i,
    output logic bit_stb,
    output logic bit_lr,
    output logic bit_d
);

    logic [2:0] pins_s;
    logic       sclk_d;

    sap_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, lrck_i, sdata_i}),
        .q     (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= pins_s[2];
        end
    end

    // Word clock and data are taken with the same synchronizer delay as the bit clock
    assign bit_stb = pins_s[2] & ~sclk_d;
    assign bit_lr  = pins_s[1];
    assign bit_d   = pins_s[0];

endmodule

// File: rtl/sap_shift.sv
module sap_shift
    import sap_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int RJ_W     = 16,
    parameter int SLOT_MAX = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              lr,
    input  logic              d,
    input  fmt_e              fmt,
    output logic              boundary,
    output logic [DATA_W-1:0] commit_word
);

    localparam int                CNT_W   = $clog2(SLOT_MAX);
    localparam logic [CNT_W-1:0]  IDX_MAX = '1;
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  idx_q, idx_now, idx_nx;
    logic [DATA_W-1:0] word_q, word_base, word_nx, hot;
    logic [RJ_W-1:0]   tail_q;
    logic              lr_prev_q;
    int                pos;

    assign boundary    = stb && (lr != lr_prev_q);
    assign commit_word = (fmt == FMT_RJ) ? {tail_q, {(DATA_W-RJ_W){1'b0}}} : word_q;

    always_comb begin
        idx_now   = boundary ? '0 : idx_q;
        word_base = boundary ? '0 : word_q;
        case (fmt)
            FMT_LJ:  pos = DATA_W - 1 - int'(idx_now);
            FMT_I2S: pos = (idx_now == '0) ? -1 : DATA_W - int'(idx_now);
            default: pos = -1;
        endcase
        hot     = (pos >= 0 && pos < DATA_W) ? (ONE << pos) : '0;
        word_nx = d ? (word_base | hot) : (word_base & ~hot);
        idx_nx  = (idx_now == IDX_MAX) ? idx_now : idx_now + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            word_q    <= '0;
            tail_q    <= '0;
            lr_prev_q <= 1'b0;
        end else if (stb) begin
            idx_q     <= idx_nx;
            word_q    <= word_nx;
            tail_q    <= {tail_q[RJ_W-2:0], d};
            lr_prev_q <= lr;
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sap_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int RJ_W        = 16,
    parameter int SLOT_MAX    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              lrck_i,
    input  logic              sdata_i,
    input  logic [2:0]        fmt_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o
);

    fmt_e              fmt;
    logic [2:0]        fmt_q;
    logic              fmt_chg;
    logic              bit_stb, bit_lr, bit_d;
    logic              boundary, left_now;
    logic [DATA_W-1:0] commit_word, hold_q;
    state_e            state_q, state_d;

    assign fmt      = decode_fmt(fmt_i);
    assign fmt_chg  = (fmt_i != fmt_q);
    assign left_now = (fmt == FMT_I2S) ? ~bit_lr : bit_lr;

    sap_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .lrck_i  (lrck_i),
        .sdata_i (sdata_i),
        .bit_stb (bit_stb),
        .bit_lr  (bit_lr),
        .bit_d   (bit_d)
    );

    sap_shift #(
        .DATA_W   (DATA_W),
        .RJ_W     (RJ_W),
        .SLOT_MAX (SLOT_MAX)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (bit_stb),
        .lr          (bit_lr),
        .d           (bit_d),
        .fmt         (fmt),
        .boundary    (boundary),
        .commit_word (commit_word)
    );

    always_comb begin
        state_d = state_q;
        if (fmt_chg) begin
            state_d = ST_IDLE;
        end else if (boundary) begin
            unique case (state_q)
                ST_IDLE:  state_d = left_now ? ST_LEFT : ST_SKIP;
                ST_LEFT:  state_d = ST_RIGHT;
                ST_RIGHT: state_d = ST_LEFT;
                ST_SKIP:  state_d = ST_LEFT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= '0;
        end else begin
            state_q <= state_d;
            fmt_q   <= fmt_i;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (!fmt_chg && boundary) begin
                unique case (state_q)
                    ST_LEFT: hold_q <= commit_word;
                    ST_RIGHT: begin
                        left_o  <= hold_q;
                        right_o <= commit_word;
                        valid_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int DATA_W = 24,
    parameter int RJ_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        fmt_i,
    input logic [DATA_W-1:0] left_o,
    input logic [DATA_W-1:0] right_o,
    input logic              valid_o
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R6

    AST_RJ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(fmt_i) == 3'b010) |->
            (left_o[DATA_W-RJ_W-1:0] == '0 && right_o[DATA_W-RJ_W-1:0] == '0)); // R4

    AST_FMT_CHANGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i != $past(fmt_i)) |=> !valid_o); // R8

endmodule

bind serial_audio_rx serial_audio_rx_chk #(
    .DATA_W (DATA_W),
    .RJ_W   (RJ_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_i   (fmt_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/test_serial_audio_rx.sv
`timescale 1ns/1ps
module test_serial_audio_rx;

    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit junk_v = 1'b0;
    logic [47:0] sb_q[$];

    always #5 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk),
        .lrck_i  (lrck),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0]  hist[$];
    int          m_state, m_idx, m_f;
    bit          m_prev, m_v;
    bit [23:0]   m_word, m_hold, m_l, m_r, m_cw;
    bit [15:0]   m_tail;
    bit [2:0]    m_fq;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000, 3'b000};
            m_state = 0; m_idx = 0; m_prev = 0; m_v = 0;
            m_word = 0; m_hold = 0; m_l = 0; m_r = 0; m_tail = 0; m_fq = 0;
        end else begin
            bit chg, rise, lr, d, bnd, lnow;
            hist.push_back({sclk, lrck, sdata});
            void'(hist.pop_front());
            m_v = 0;
            m_f = (fmt == 3'b001) ? 1 : (fmt == 3'b010) ? 2 : 0;
            chg = (fmt != m_fq);
            m_fq = fmt;
            rise = hist[1][2] && !hist[0][2];
            if (rise) begin
                lr = hist[1][1];
                d = hist[1][0];
                bnd = (lr != m_prev);
                lnow = (m_f == 1) ? !lr : lr;
                m_cw = (m_f == 2) ? {m_tail, 8'h00} : m_word;
                if (!chg && bnd) begin
                    case (m_state)
                        0: m_state = lnow ? 1 : 3;
                        1: begin m_hold = m_cw; m_state = 2; end
                        2: begin m_l = m_hold; m_r = m_cw; m_v = 1; m_state = 1; end
                        default: m_state = 1;
                    endcase
                end
                if (bnd) begin m_idx = 0; m_word = 0; end
                if (m_f == 0 && m_idx < 24) m_word[23 - m_idx] = d;
                if (m_f == 1 && m_idx >= 1 && m_idx <= 24) m_word[24 - m_idx] = d;
                m_tail = {m_tail[14:0], d};
                if (m_idx < 63) m_idx++;
                m_prev = lr;
            end
            if (chg) m_state = 0;
        end
    end

    // Per-clock comparison and scoreboard, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({tag, " R6 model"}, {15'd0, valid_o, left_o, right_o}, {15'd0, m_v, m_l, m_r});
            if (valid_o) begin
                if (sb_q.size() == 0) begin
                    check({tag, " R7 unexpected valid"}, 64'd1, 64'd0);
                end else begin
                    check({tag, " pair"}, {16'd0, left_o, right_o}, {16'd0, sb_q.pop_front()});
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input bit lr, input bit d);
        @(negedge clk);
        sclk = 1'b0; lrck = lr; sdata = d;
        repeat (HP - 1) @(negedge clk);
        sclk = 1'b1;
        repeat (HP - 1) @(negedge clk);
    endtask

    function automatic int eff(input bit [2:0] code);
        return (code == 3'b001) ? 1 : (code == 3'b010) ? 2 : 0;
    endfunction

    task automatic channel(input bit isleft, input bit [23:0] w24, input int w, input int slot);
        int f = eff(fmt);
        bit lvl = (f == 1) ? !isleft : isleft;
        for (int i = 0; i < slot; i++) begin
            bit b = junk_v;
            if (f == 0 && i < w) b = w24[23 - i];
            if (f == 1 && i >= 1 && i <= w) b = w24[24 - i];
            if (f == 2 && i >= slot - 16) b = w24[23 - (i - (slot - 16))];
            send_bit(lvl, b);
        end
    endtask

    task automatic frame(input bit [23:0] l, input bit [23:0] r, input int w, input int slot, input bit expv);
        if (expv) sb_q.push_back({l, r});
        channel(1'b1, l, w, slot);
        channel(1'b0, r, w, slot);
    endtask

    // Starts a left slot, checking the strobe latency and width (R10, R6)
    task automatic tail_bit();
        bit lvl = (eff(fmt) == 1) ? 1'b0 : 1'b1;
        @(negedge clk);
        sclk = 1'b0; lrck = lvl; sdata = 1'b0;
        repeat (HP - 1) @(negedge clk);
        sclk = 1'b1;
        @(negedge clk); check("R10 latency edge1", {63'd0, valid_o}, 64'd0);
        @(negedge clk); check("R10 latency edge2", {63'd0, valid_o}, 64'd0);
        @(negedge clk); check("R10 latency edge3", {63'd0, valid_o}, 64'd1);
        @(negedge clk); check("R6 pulse width", {63'd0, valid_o}, 64'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input bit [2:0] code);
        @(negedge clk);
        rst_n = 1'b0; sclk = 1'b0; lrck = 1'b0; sdata = 1'b0; fmt = code;
        repeat (3) @(negedge clk);
        check("R1 reset left", {40'd0, left_o}, 64'd0);
        check("R1 reset right", {40'd0, right_o}, 64'd0);
        check("R1 reset valid", {63'd0, valid_o}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic phase_end(input string req);
        check({req, " all pairs delivered"}, sb_q.size(), 64'd0);
        sb_q.delete();
    endtask

    initial begin
        // R2: 24-bit left-justified, slots of exactly 24 bits
        do_reset(3'b000);
        tag = "R2";
        frame(24'hA5C3F1, 24'h0F1E2D, 24, 24, 1);
        frame(24'h800001, 24'h7FFFFE, 24, 24, 1);
        frame(24'h123456, 24'hFEDCBA, 24, 24, 1);
        tail_bit();
        phase_end("R2");

        // R2: 16-bit words in 16-bit slots, low byte must be zero padded
        do_reset(3'b000);
        tag = "R2 pad";
        frame(24'hFFFF00, 24'hFFFF00, 24, 24, 1);
        frame(24'h5A5A00, 24'hC3C300, 16, 16, 1);
        frame(24'h000100, 24'h800000, 16, 16, 1);
        tail_bit();
        phase_end("R2");

        // R9: 32-bit slots with ones after the 24th bit
        do_reset(3'b000);
        tag = "R9"; junk_v = 1'b1;
        frame(24'h00F000, 24'h000001, 24, 32, 1);
        frame(24'h000000, 24'h0A0B0C, 24, 32, 1);
        tail_bit();
        phase_end("R9");

        // R3 and R7: I2S, first frame lost because its left slot has no transition
        do_reset(3'b001);
        tag = "R3"; junk_v = 1'b1;
        frame(24'h111111, 24'h222222, 24, 32, 0);
        frame(24'hABCDEF, 24'h00FF00, 24, 32, 1);
        frame(24'h800000, 24'h000001, 24, 32, 1);
        tail_bit();
        phase_end("R7");

        // R4: right-justified 16-bit in 32-bit slots with junk leading bits
        do_reset(3'b010);
        tag = "R4"; junk_v = 1'b1;
        frame(24'hBEEF00, 24'h12AB00, 16, 32, 1);
        frame(24'h000100, 24'hFFFF00, 16, 32, 1);
        tail_bit();
        phase_end("R4");

        // R5: unlisted codes behave as left-justified
        do_reset(3'b111);
        tag = "R5"; junk_v = 1'b0;
        frame(24'h13579B, 24'h2468AC, 24, 24, 1);
        tail_bit();
        phase_end("R5");
        do_reset(3'b100);
        frame(24'hC0FFEE, 24'h0DDBA1, 24, 24, 1);
        tail_bit();
        phase_end("R5");

        // R8: code switch inside a right slot abandons that frame
        do_reset(3'b000);
        tag = "R8"; junk_v = 1'b1;
        frame(24'h0A0A0A, 24'h505050, 24, 24, 1);
        channel(1'b1, 24'h777777, 24, 24);
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);
        fmt = 3'b010;
        for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1);
        frame(24'h9ABC00, 24'h432100, 16, 32, 1);
        frame(24'h00FF00, 24'hFF0000, 16, 32, 1);
        tail_bit();
        phase_end("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule